// File: doc/BRIEF.md
# Dual-Mode Serial Transmitter with Optional Hamming Protection

This block turns a parallel word from a processor into an asynchronous serial frame on a single output line. The processor presents a byte, a mode select and a word-length code, then pulls an active-low write strobe low. The transmitter captures a complete frame image at that moment and drops its ready output. Each rising edge of an externally supplied baud clock then drives one frame bit onto the line. Ready returns high once the stop bit has been on the line for a full baud period.

There are two frame formats. In plain mode the frame carries 5 to 8 data bits followed by an even-parity bit. In protected mode only the low nibble is sent, as an 8-bit extended Hamming codeword that can correct one bit error and detect two. The slot that carries parity in plain mode then holds a constant one, so a protected frame is always 11 bits long. The baud clock is generated outside the block. It is sampled in the system clock domain, and each rising edge of it advances the frame by one bit.

Top module: `dual_uart_tx`

## Requirements
- R1: After reset, and whenever ready is high, `txd` is 1. Ready is 1 after reset.
- R2: A falling edge of `wr_n` while ready is high captures `din`, `mode` and `wlen`, and ready reads 0 from the following clock cycle.
- R3: The first rising edge of `baud_clk` after capture drives the start bit (0). Each later rising edge drives the next bit, and the last bit of every frame is a stop bit (1). `txd` changes only in the cycle after a baud rising edge.
- R4: With `mode`=0, `wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. These are `din[N-1:0]`, sent least significant bit first.
- R5: With `mode`=0, the bit after the data bits is the even parity of the selected data bits, so the data bits and this bit hold an even number of ones.
- R6: With `mode`=1 and nibble d=`din[3:0]`, eight code bits follow the start bit in this order: c0=d0^d1^d3, c1=d0^d2^d3, c2=d0^d1^d2, c3 (the XOR of d and c0..c2), then d0, d1, d2, d3. For example, nibble 0001 gives the codeword 0001_0111, written MSB to LSB.
- R7: With `mode`=1, the slot after the codeword is a constant 1. `wlen` and `din[7:4]` have no effect on the frame.
- R8: Ready returns to 1 on the first baud rising edge after the stop bit has been driven. `txd` then stays 1 until the next write.
- R9: A write strobe, or a change to `din`, `mode` or `wlen`, while ready is 0 has no effect on the frame in progress and does not queue another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_clk | input | 1 | Baud clock; each rising edge advances one bit |
| wr_n | input | 1 | Active-low write strobe; its falling edge loads a frame |
| din | input | 8 | Data word from the processor |
| mode | input | 1 | 0 = parity frame, 1 = Hamming-protected frame |
| wlen | input | 2 | Data length code for parity frames (5 + code bits) |
| txd | output | 1 | Serial output line, idle high |
| ready | output | 1 | High when a new write is accepted |

## Verification
The hardest case to reach is a write strobe that arrives mid-frame, together with changed mode, length and data. In that case the in-flight frame must remain intact and no second frame may be queued. The bench fires this strobe after the fourth bit of a frame and keeps the altered inputs in place to the end. It then compares every remaining bit with the originally captured frame and watches the line and ready over several idle baud periods. The sweep covers every protected-mode nibble and all four plain-mode lengths with several data patterns. The writes are aligned to the baud falling edge, so capture never collides with a baud rising edge.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int LEN_W   = 2;
  localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1;
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // Extended Hamming (8,4): check bits in [3:0], data nibble in [7:4]
  function automatic logic [7:0] ham84_encode(input logic [3:0] d);
    logic [3:0] c;
    c[0] = d[0] ^ d[1] ^ d[3];
    c[1] = d[0] ^ d[2] ^ d[3];
    c[2] = d[0] ^ d[1] ^ d[2];
    c[3] = ^{d, c[2:0]};
    return {d, c};
  endfunction
endpackage

// File: rtl/uart_edge_detect.sv
module uart_edge_detect #(
  parameter bit INIT    = 1'b0,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic pulse
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= INIT;
    else     sig_q <= sig;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = sig_q & ~sig;
    end else begin : g_rise
      assign pulse = ~sig_q & sig;
    end
  endgenerate
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
(
  input  logic [DATA_W-1:0]  din,
  input  logic               mode,
  input  logic [LEN_W-1:0]   wlen,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  logic [7:0] code;
  logic       par;
  int         n;

  always_comb begin
    code  = ham84_encode(din[3:0]);
    par   = 1'b0;
    n     = MIN_LEN + int'(wlen);
    frame = '1;
    frame[0] = 1'b0;
    if (mode) begin
      for (int i = 0; i < 8; i++) frame[i+1] = code[i];
      frame[9] = 1'b1;
      nbits    = CNT_W'(FRAME_W);
    end else begin
      for (int i = 0; i < DATA_W; i++) begin
        if (i < n) begin
          frame[i+1] = din[i];
          par        = par ^ din[i];
        end
      end
      frame[n+1] = par;
      nbits      = CNT_W'(n + 3);
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  input  logic               tick,
  output logic               txd,
  output logic               ready
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '1;
      remain <= '0;
      ready  <= 1'b1;
      txd    <= 1'b1;
    end else if (ready) begin
      if (load) begin
        shreg  <= frame_in;
        remain <= nbits_in;
        ready  <= 1'b0;
      end
    end else if (tick) begin
      if (remain != '0) begin
        txd    <= shreg[0];
        shreg  <= {1'b1, shreg[FRAME_W-1:1]};
        remain <= remain - 1'b1;
      end else begin
        ready  <= 1'b1;
      end
    end
  end

  // R9: a strobe during a frame leaves the held frame untouched
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!ready && load && !tick) |=> $stable(shreg) && $stable(remain));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    remain <= CNT_W'(FRAME_W));

  // R3: the first bit driven after a load is the start bit
  assert_start_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (!ready && tick && remain == nbits_in && $past(ready)) |=> !txd);
endmodule

// File: rtl/dual_uart_tx.sv
module dual_uart_tx
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_clk,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  input  logic              mode,
  input  logic [LEN_W-1:0]  wlen,
  output logic              txd,
  output logic              ready
);
  logic               tick;
  logic               wr_fall;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  uart_edge_detect #(.INIT(1'b0), .FALLING(1'b0)) u_baud_edge (
    .clk(clk), .rst(rst), .sig(baud_clk), .pulse(tick)
  );

  uart_edge_detect #(.INIT(1'b1), .FALLING(1'b1)) u_wr_edge (
    .clk(clk), .rst(rst), .sig(wr_n), .pulse(wr_fall)
  );

  uart_tx_framer u_framer (
    .din(din), .mode(mode), .wlen(wlen), .frame(frame), .nbits(nbits)
  );

  uart_tx_shifter u_shifter (
    .clk(clk), .rst(rst), .load(wr_fall), .frame_in(frame),
    .nbits_in(nbits), .tick(tick), .txd(txd), .ready(ready)
  );

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    ready |-> txd);

  assert_write_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (ready && wr_fall) |=> !ready);

  assert_txd_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd));

  assert_ready_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(tick));
endmodule

// File: tb/dual_uart_tx_bench.sv
module dual_uart_tx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_clk = 1'b0;
  logic       wr_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic       mode = 1'b0;
  logic [1:0] wlen = 2'd0;
  logic       txd;
  logic       ready;

  int checks = 0;
  int errors = 0;

  dual_uart_tx u_dual_uart_tx (
    .clk(clk), .rst(rst), .baud_clk(baud_clk), .wr_n(wr_n),
    .din(din), .mode(mode), .wlen(wlen), .txd(txd), .ready(ready)
  );

  always #10 clk = ~clk;       // 50 MHz
  always #80 baud_clk = ~baud_clk;

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  function automatic logic [7:0] ham_ref(input logic [3:0] d);
    logic c0, c1, c2, c3;
    c0 = d[0] ^ d[1] ^ d[3];
    c1 = d[0] ^ d[2] ^ d[3];
    c2 = d[0] ^ d[1] ^ d[2];
    c3 = d[0] ^ d[1] ^ d[2] ^ d[3] ^ c0 ^ c1 ^ c2;
    return {d, c3, c2, c1, c0};
  endfunction

  // Send one frame; optionally fire a disturbing write mid-frame (R9)
  task automatic send(input logic m, input logic [1:0] wl, input logic [7:0] d, input bit disturb);
    logic [10:0] exp;
    int nb, n;
    logic par;
    logic [7:0] code;
    exp = '1; exp[0] = 1'b0;
    if (m) begin
      code = ham_ref(d[3:0]);
      for (int i = 0; i < 8; i++) exp[i+1] = code[i];
      exp[9] = 1'b1;
      nb = 11;
    end else begin
      n = 5 + int'(wl);
      par = 1'b0;
      for (int i = 0; i < n; i++) begin exp[i+1] = d[i]; par = par ^ d[i]; end
      exp[n+1] = par;
      nb = n + 3;
    end
    @(negedge baud_clk);
    check("R1", txd, 1'b1, "idle line before write");
    mode = m; wlen = wl; din = d;
    wr_n = 1'b0;
    @(negedge clk); @(negedge clk);
    wr_n = 1'b1;
    check("R2", ready, 1'b0, "ready after write");
    for (int k = 0; k < nb; k++) begin
      @(negedge baud_clk);
      if (k == 0)           check("R3", txd, exp[k], "start bit");
      else if (k == nb - 1) check("R3", txd, exp[k], "stop bit");
      else if (m)           check(k == nb - 2 ? "R7" : "R6", txd, exp[k], $sformatf("ecc bit %0d", k));
      else                  check(k == nb - 2 ? "R5" : "R4", txd, exp[k], $sformatf("data bit %0d", k));
      if (k == nb - 1) check("R8", ready, 1'b0, "ready during stop bit");
      if (disturb && k == 3) begin
        mode = ~m; wlen = ~wl; din = ~d;
        @(negedge clk);
        wr_n = 1'b0;
        @(negedge clk); @(negedge clk);
        wr_n = 1'b1;
        check("R9", ready, 1'b0, "ready after busy write");
      end
    end
    @(negedge baud_clk);
    check("R8", ready, 1'b1, "ready after stop");
    check("R8", txd, 1'b1, "line high after stop");
    if (disturb) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge baud_clk);
        check("R9", txd, 1'b1, "no queued frame on line");
        check("R9", ready, 1'b1, "no queued frame ready");
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", ready, 1'b1, "ready after reset");
    check("R1", txd, 1'b1, "txd after reset");
    // Protected mode: every nibble, varied upper bits and length code (R6, R7)
    for (int v = 0; v < 16; v++)
      send(1'b1, 2'(v), {4'(15 - v), 4'(v)}, 1'b0);
    // Plain mode: all lengths, several patterns (R4, R5)
    for (int l = 0; l < 4; l++) begin
      send(1'b0, 2'(l), 8'h00, 1'b0);
      send(1'b0, 2'(l), 8'hFF, 1'b0);
      send(1'b0, 2'(l), 8'hA5, 1'b0);
      send(1'b0, 2'(l), 8'h5A, 1'b0);
      send(1'b0, 2'(l), 8'h37, 1'b0);
      send(1'b0, 2'(l), 8'h81, 1'b0);
    end
    // Busy writes ignored (R9), both modes
    send(1'b0, 2'd3, 8'hC6, 1'b1);
    send(1'b1, 2'd0, 8'h09, 1'b1);
    send(1'b0, 2'd1, 8'h2B, 1'b1);
    finish_run();
  end
endmodule